// File: doc/BRIEF.md
# Timer Output Compare Reference Generator

This block turns a running timer count into the reference levels of two output channels. Each clock it compares the count with a per-channel compare value. It then applies the 4-bit mode selected for that channel and registers the result. Two event inputs, an update pulse and a trigger pulse, drive a one-pulse mode that can be retriggered. For channel A it also drives a combined reference. Depending on channel A's mode, this output is the OR or the AND of both channel references, or it picks one of them by count direction.

The count, the direction, the events and both control words come from the timer core around it. Dead-time, polarity and output enables are applied later, outside this block. The mode is read from a register-style control word in which the field is split into two pieces.

Top module: `tim_ocref_gen`

## Requirements
- R1: While `rst_n` is low, `ref_a`, `ref_b` and `ref_comb` are 0, and the trigger-armed state is cleared.
- R2: A channel's mode is `{ctl[16], ctl[6:4]}`, and all other control bits are ignored. Channel B decodes its mode into `ref_b` exactly as channel A decodes into `ref_a`.
- R3: Mode 0 (frozen) holds the reference at its previous value, whatever the count and the compare value are.
- R4: Modes 1, 2 and 3 drive the reference to 1, drive it to 0, or invert it, but only in cycles where the count equals the compare value; otherwise they hold it. Mode 4 forces 0 and mode 5 forces 1.
- R5: Mode 6 gives a level that is 1 when the count is below the compare value while counting up (`cnt_down`=0), and 1 when the count is not above the compare value while counting down. Mode 7 gives the inverse of mode 6.
- R6: A trigger pulse arms a shared one-pulse state, and an update pulse disarms it; a trigger wins when both arrive in the same cycle. In mode 8 the reference follows the mode 6 level while armed. While not armed it is 1 when counting up and 0 when counting down.
- R7: Mode 9 gives the inverse of the mode 8 result under the same conditions.
- R8: The reserved modes 10 and 11 drive the reference to 0.
- R9: In modes 12 and 13 the primary reference follows mode 6 and mode 7 respectively. In mode 12 `ref_comb` is `ref_a | ref_b`, and in mode 13 it is `ref_a & ref_b`.
- R10: In modes 14 and 15 the primary reference follows mode 6 and mode 7 respectively. `ref_comb` takes the new `ref_a` when the count direction in that cycle was up, and the new `ref_b` when it was down.
- R11: For channel A modes 0 to 11, `ref_comb` equals `ref_a`.
- R12: All outputs are registered. A change of input or mode shows on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | CNT_W | Current timer count |
| cnt_down | input | 1 | 1 while the timer counts down |
| upd_evt | input | 1 | Single-cycle update event |
| trg_evt | input | 1 | Single-cycle trigger event |
| cmp_a | input | CNT_W | Channel A compare value |
| cmp_b | input | CNT_W | Channel B compare value |
| ctl_a | input | 17 | Channel A control word (mode in bits 16 and 6:4) |
| ctl_b | input | 17 | Channel B control word (mode in bits 16 and 6:4) |
| ref_a | output | 1 | Channel A reference |
| ref_b | output | 1 | Channel B reference |
| ref_comb | output | 1 | Channel A combined reference |

## Verification
The assertions assume that the count, direction and compare inputs are stable for a whole cycle and have defined values from reset onward. They also treat the event inputs as pulses, whose level in a given cycle matters only in that cycle. The stimulus meets these assumptions by changing inputs only on the falling edge. The count sweeps a triangle from 0 to 15 and back, with update pulses at both turning points. Compare values include 0 and values above the sweep top, so a level that is always high or always low is covered. The control words carry random bits outside the mode field. Trigger pulses are pseudo-random and sometimes coincide with an update.

// File: rtl/tim_ocref_gen.sv
module tim_ocref_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_down,
  input  logic             upd_evt,
  input  logic             trg_evt,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [16:0]      ctl_a,
  input  logic [16:0]      ctl_b,
  output logic             ref_a,
  output logic             ref_b,
  output logic             ref_comb
);

  localparam int MODE_W = 4;

  logic [MODE_W-1:0] mode_a, mode_b;
  logic armed_q, armed_now;
  logic nxt_a, nxt_b, nxt_c;

  assign mode_a    = {ctl_a[16], ctl_a[6:4]};
  assign mode_b    = {ctl_b[16], ctl_b[6:4]};
  assign armed_now = trg_evt | (armed_q & ~upd_evt);

  function automatic logic level(input logic [MODE_W-1:0] m, input logic cur,
                                 input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] k,
                                 input logic dn, input logic arm);
    logic pw, hit, op;
    pw  = dn ? (c <= k) : (c < k);
    hit = (c == k);
    op  = arm ? pw : ~dn;
    case (m)
      4'd0:  level = cur;
      4'd1:  level = hit ? 1'b1 : cur;
      4'd2:  level = hit ? 1'b0 : cur;
      4'd3:  level = hit ? ~cur : cur;
      4'd4:  level = 1'b0;
      4'd5:  level = 1'b1;
      4'd6,  4'd12, 4'd14: level = pw;
      4'd7,  4'd13, 4'd15: level = ~pw;
      4'd8:  level = op;
      4'd9:  level = ~op;
      default: level = 1'b0;
    endcase
  endfunction

  assign nxt_a = level(mode_a, ref_a, cnt, cmp_a, cnt_down, armed_now);
  assign nxt_b = level(mode_b, ref_b, cnt, cmp_b, cnt_down, armed_now);

  always_comb begin
    case (mode_a)
      4'd12:        nxt_c = nxt_a | nxt_b;
      4'd13:        nxt_c = nxt_a & nxt_b;
      4'd14, 4'd15: nxt_c = cnt_down ? nxt_b : nxt_a;
      default:      nxt_c = nxt_a;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      ref_a    <= 1'b0;
      ref_b    <= 1'b0;
      ref_comb <= 1'b0;
    end else begin
      armed_q  <= armed_now;
      ref_a    <= nxt_a;
      ref_b    <= nxt_b;
      ref_comb <= nxt_c;
    end
  end

  assert_frozen_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_a) == 4'd0 |-> $stable(ref_a));
  assert_force_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_a) == 4'd4 |-> !ref_a);
  assert_force_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_a) == 4'd5 |-> ref_a);
  assert_pwm_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_a == 4'd6 && !cnt_down) |-> ref_a == $past(cnt < cmp_a));
  assert_reserved_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_a) == 4'd10 || $past(mode_a) == 4'd11) |-> !ref_a);
  assert_comb_or_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_a) == 4'd12 |-> ref_comb == (ref_a | ref_b));
  assert_comb_and_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_a) == 4'd13 |-> ref_comb == (ref_a & ref_b));
  assert_asym_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_a >= 4'd14 && !cnt_down) |-> ref_comb == ref_a);
  assert_asym_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_a >= 4'd14 && cnt_down) |-> ref_comb == ref_b);
  assert_comb_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_a) < 4'd12 |-> ref_comb == ref_a);

endmodule

// File: tb/tim_ocref_gen_tb.sv
module tim_ocref_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] cnt = '0, cmp_a = '0, cmp_b = '0;
  logic cnt_down = 1'b0, upd_evt = 1'b0, trg_evt = 1'b0;
  logic [16:0] ctl_a = '0, ctl_b = '0;
  logic ref_a, ref_b, ref_comb;

  int n_chk = 0, n_fail = 0;
  bit m_arm, m_a, m_b, m_c;
  int unsigned lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  tim_ocref_gen #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_down(cnt_down), .upd_evt(upd_evt),
    .trg_evt(trg_evt), .cmp_a(cmp_a), .cmp_b(cmp_b), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .ref_a(ref_a), .ref_b(ref_b), .ref_comb(ref_comb));

  function automatic bit model_lvl(int m, bit cur, int c, int k, bit dn, bit arm);
    bit pw;
    pw = dn ? (c <= k) : (c < k);
    if (m == 0) return cur;
    if (m == 1) return (c == k) ? 1'b1 : cur;
    if (m == 2) return (c == k) ? 1'b0 : cur;
    if (m == 3) return (c == k) ? !cur : cur;
    if (m == 4) return 1'b0;
    if (m == 5) return 1'b1;
    if (m == 6 || m == 12 || m == 14) return pw;
    if (m == 7 || m == 13 || m == 15) return !pw;
    if (m == 8) return arm ? pw : !dn;
    if (m == 9) return arm ? !pw : dn;
    return 1'b0;
  endfunction

  function automatic string tag_of(int m);
    if (m == 0) return "R3";
    if (m <= 5) return "R4";
    if (m <= 7) return "R5";
    if (m == 8) return "R6";
    if (m == 9) return "R7";
    if (m <= 11) return "R8";
    if (m <= 13) return "R9";
    return "R10";
  endfunction

  function automatic int mode_of(logic [16:0] w);
    return int'({w[16], w[6:4]});
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_arm = 0; m_a = 0; m_b = 0; m_c = 0;
    end else begin
      bit arm, na, nb;
      int ma;
      ma  = mode_of(ctl_a);
      arm = trg_evt || (m_arm && !upd_evt);
      na  = model_lvl(ma, m_a, int'(cnt), int'(cmp_a), cnt_down, arm);
      nb  = model_lvl(mode_of(ctl_b), m_b, int'(cnt), int'(cmp_b), cnt_down, arm);
      if (ma == 12) m_c = na | nb;
      else if (ma == 13) m_c = na & nb;
      else if (ma >= 14) m_c = cnt_down ? nb : na;
      else m_c = na;
      m_a = na; m_b = nb; m_arm = arm;
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s t=%0t actual=%b expected=%b", tag, what, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    int ma;
    ma = mode_of(ctl_a);
    chk(tag_of(ma), "ref_a (R12 one-edge latency)", ref_a, m_a);
    chk("R2", "ref_b same decode", ref_b, m_b);
    chk(ma < 12 ? "R11" : tag_of(ma), "ref_comb", ref_comb, m_c);
  endtask

  function automatic logic [16:0] junk_ctl(int m, int unsigned r);
    logic [16:0] w;
    w = r[16:0];
    w[6:4] = m[2:0];
    w[16]  = m[3];
    return w;
  endfunction

  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ref_a in reset", ref_a, 1'b0);
    chk("R1", "ref_b in reset", ref_b, 1'b0);
    chk("R1", "ref_comb in reset", ref_comb, 1'b0);
    rst_n = 1'b1;
    for (int ma = 0; ma < 16; ma++) begin
      for (int j = 0; j < 4; j++) begin
        int mb;
        mb = (j == 0) ? 6 : (j == 1) ? 7 : (j == 2) ? ma : 3;
        for (int k = 0; k < 64; k++) begin
          int pos;
          pos = k % 32;
          @(negedge clk);
          compare_all();
          lcg = lcg * 1103515245 + 12345;
          ctl_a    = junk_ctl(ma, lcg >> 7);
          ctl_b    = junk_ctl(mb, lcg >> 11);
          cmp_a    = W'((ma * 5 + j * 3 + k / 32) % 18);
          cmp_b    = W'((ma * 3 + j * 7 + 2) % 17);
          cnt      = W'(pos < 16 ? pos : 31 - pos);
          cnt_down = (pos >= 16);
          upd_evt  = (pos == 0) || (pos == 16);
          trg_evt  = (lcg[30:28] == 3'd0) || (upd_evt && (k % 3 == 0));
        end
      end
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule